// File: doc/BRIEF.md
# Dispatch Use-Count Extractor and Prefix Fuser

This unit sits at the dispatch stage and receives one 32-bit instruction word per handshake. Each instruction that writes a destination register carries a 3-bit count of how many later instructions are expected to read that result. The value 7 means seven or more readers. The unit removes this count from the word, rebuilds the instruction fields a later decoder expects, and presents the count next to a 64-bit sign-extended displacement. Register-operate words keep the count in spare function-code bits. Load/store words keep it in the top three bits of what used to be a 16-bit displacement, which leaves only 13 displacement bits.

A displacement that does not fit in 13 bits travels in a dedicated prefix word placed just before the memory instruction. The unit absorbs the prefix and produces no output for it. It then joins the prefix's full 16-bit offset to the following memory instruction, so the pair leaves as a single dispatch slot. An interrupt or context-switch flush discards a prefix that is still waiting. Fetch later restarts at the prefix, so nothing is lost.

Top module: `dispatch_usecount_fuser`

## Requirements
- R1: After reset no prefix is held. `out_valid` is low, and with `in_valid` low and `out_ready` high, `in_ready` is high.
- R2: A word whose opcode bits [31:26] have [31:30] = 2'b01 is register-operate. Its use count is bits [11:9], `out_instr` equals the word with bits [11:9] cleared, `out_disp` is 0 and `out_is_mem` is 0.
- R3: A word whose opcode has [31:30] = 2'b10 is a memory instruction. Its use count is bits [15:13]. When no prefix is held, `out_disp` is bits [12:0] sign-extended to 64 bits, and `out_instr` keeps bits [31:16] with bits [15:0] replaced by the low 16 bits of `out_disp`. A count of 7 passes through unchanged.
- R4: A word with any other opcode, except the prefix code, passes through unchanged. It gets use count 0, displacement 0 and `out_fused` = 0.
- R5: A word with opcode 6'h3F is a prefix. Whenever `flush` is low it is accepted (`in_ready` high), even while `out_ready` is low. It never raises `out_valid`, and its bits [15:0] are held.
- R6: A memory word that arrives while a prefix is held takes the held 16 bits, sign-extended, as `out_disp` and as `out_instr[15:0]`. It keeps its own [15:13] as the use count, sets `out_fused` = 1, and consumes the prefix.
- R7: A register-operate or other word that arrives while a prefix is held is emitted exactly as without the prefix, with `out_fused` = 0. The prefix is dropped, so a later memory word is not fused.
- R8: A second prefix that arrives while one is already held replaces it.
- R9: While `flush` is high, `in_ready` and `out_valid` are low, and any held prefix is discarded.
- R10: A non-prefix word transfers when `in_valid` and `out_ready` are both high, and `in_ready` follows `out_ready`. While the output is stalled, the word stays presented and a held prefix is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Interrupt/context-switch discard of a held prefix |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle |
| in_instr | input | 32 | Incoming instruction word |
| out_valid | output | 1 | Dispatch slot valid |
| out_ready | input | 1 | Downstream accepts the slot |
| out_instr | output | 32 | Rebuilt instruction word |
| out_opcode | output | 6 | Opcode field |
| out_ra | output | 5 | First register field |
| out_rb | output | 5 | Second register field |
| out_disp | output | 64 | Sign-extended displacement |
| out_use_count | output | 3 | Extracted destination use count |
| out_is_mem | output | 1 | Slot is a memory instruction |
| out_fused | output | 1 | Slot was joined with a prefix |

## Verification
The case that needs the most care is a flush that lands in the same cycle as the memory word following a held prefix. Two things happen in that cycle: the prefix is discarded, and the follower is refused. The bench holds a prefix, raises `flush` with the follower already presented, and checks that the follower is neither emitted nor accepted. It then presents the follower again after the flush and expects the short 13-bit displacement with `out_fused` low. A second overlap is a stalled output while a prefix is waiting. In that case `out_valid` must stay high with the fused value until `out_ready` rises.

// File: rtl/ucx_pkg.sv
package ucx_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int IMM_W    = 16;
    localparam int UC_W     = 3;
    localparam int SHORT_W  = IMM_W - UC_W;
    localparam int DISP_W   = 64;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int RA_LSB   = OPC_LSB - REG_W;
    localparam int RB_LSB   = RA_LSB - REG_W;
    localparam int OPER_UC_LSB = 9;

    localparam logic [OPC_W-1:0] PREFIX_OPC = 6'h3F;

    typedef enum logic [1:0] {
        FMT_OTHER,
        FMT_OPER,
        FMT_MEM,
        FMT_PREFIX
    } fmt_e;

    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [DISP_W-1:0]  disp;
        logic [UC_W-1:0]    uc;
        logic               is_mem;
        logic               fused;
    } slot_t;

    function automatic fmt_e classify(logic [OPC_W-1:0] opc,
                                      logic [OPC_W-1:0] pfx);
        if (opc == pfx)                       return FMT_PREFIX;
        else if (opc[OPC_W-1 -: 2] == 2'b01)  return FMT_OPER;
        else if (opc[OPC_W-1 -: 2] == 2'b10)  return FMT_MEM;
        else                                  return FMT_OTHER;
    endfunction

    function automatic logic [DISP_W-1:0] sext_short(logic [SHORT_W-1:0] v);
        return {{(DISP_W-SHORT_W){v[SHORT_W-1]}}, v};
    endfunction

    function automatic logic [DISP_W-1:0] sext_full(logic [IMM_W-1:0] v);
        return {{(DISP_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/ucx_format_split.sv
module ucx_format_split
    import ucx_pkg::*;
#(
    parameter logic [OPC_W-1:0] PREFIX_CODE = PREFIX_OPC
) (
    input  logic [INSTR_W-1:0] instr,
    output fmt_e               fmt,
    output slot_t              base,
    output logic [IMM_W-1:0]   full_imm
);
    logic [DISP_W-1:0] short_disp;

    assign fmt        = classify(instr[INSTR_W-1 -: OPC_W], PREFIX_CODE);
    assign full_imm   = instr[IMM_W-1:0];
    assign short_disp = sext_short(instr[SHORT_W-1:0]);

    always_comb begin
        base       = '0;
        base.instr = instr;
        unique case (fmt)
            FMT_OPER: begin
                base.uc = instr[OPER_UC_LSB +: UC_W];
                base.instr[OPER_UC_LSB +: UC_W] = '0;
            end
            FMT_MEM: begin
                base.uc     = instr[IMM_W-1 -: UC_W];
                base.disp   = short_disp;
                base.is_mem = 1'b1;
                base.instr[IMM_W-1:0] = short_disp[IMM_W-1:0];
            end
            default: begin
                base.uc = '0;
            end
        endcase
    end
endmodule

// File: rtl/ucx_prefix_hold.sv
module ucx_prefix_hold
    import ucx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             load,
    input  logic [IMM_W-1:0] load_imm,
    input  logic             consume,
    output logic             held_vld,
    output logic [IMM_W-1:0] held_imm
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            held_vld <= 1'b0;
            held_imm <= '0;
        end else if (load) begin
            held_vld <= 1'b1;
            held_imm <= load_imm;
        end else if (consume) begin
            held_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/ucx_slot_merge.sv
module ucx_slot_merge
    import ucx_pkg::*;
(
    input  slot_t            base,
    input  logic             held_vld,
    input  logic [IMM_W-1:0] held_imm,
    output slot_t            merged
);
    logic [DISP_W-1:0] long_disp;

    assign long_disp = sext_full(held_imm);

    always_comb begin
        merged = base;
        if (held_vld && base.is_mem) begin
            merged.disp  = long_disp;
            merged.fused = 1'b1;
            merged.instr[IMM_W-1:0] = held_imm;
        end
    end
endmodule

// File: rtl/dispatch_usecount_fuser.sv
module dispatch_usecount_fuser
    import ucx_pkg::*;
#(
    parameter logic [OPC_W-1:0] PREFIX_CODE = PREFIX_OPC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic [OPC_W-1:0]   out_opcode,
    output logic [REG_W-1:0]   out_ra,
    output logic [REG_W-1:0]   out_rb,
    output logic [DISP_W-1:0]  out_disp,
    output logic [UC_W-1:0]    out_use_count,
    output logic               out_is_mem,
    output logic               out_fused
);
    fmt_e             fmt;
    slot_t            base;
    slot_t            merged;
    logic [IMM_W-1:0] full_imm;
    logic             held_vld;
    logic [IMM_W-1:0] held_imm;
    logic             is_prefix;
    logic             load;
    logic             consume;

    ucx_format_split #(.PREFIX_CODE(PREFIX_CODE)) i_split (
        .instr    (in_instr),
        .fmt      (fmt),
        .base     (base),
        .full_imm (full_imm)
    );

    assign is_prefix = (fmt == FMT_PREFIX);
    assign in_ready  = !flush && (is_prefix || out_ready);
    assign out_valid = in_valid && !flush && !is_prefix;
    assign load      = in_valid && !flush && is_prefix;
    assign consume   = out_valid && out_ready;

    ucx_prefix_hold i_hold (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .load     (load),
        .load_imm (full_imm),
        .consume  (consume),
        .held_vld (held_vld),
        .held_imm (held_imm)
    );

    ucx_slot_merge i_merge (
        .base     (base),
        .held_vld (held_vld),
        .held_imm (held_imm),
        .merged   (merged)
    );

    assign out_instr     = merged.instr;
    assign out_opcode    = merged.instr[OPC_LSB +: OPC_W];
    assign out_ra        = merged.instr[RA_LSB +: REG_W];
    assign out_rb        = merged.instr[RB_LSB +: REG_W];
    assign out_disp      = merged.disp;
    assign out_use_count = merged.uc;
    assign out_is_mem    = merged.is_mem;
    assign out_fused     = merged.fused;
endmodule

// File: rtl/ucx_checker.sv
module ucx_checker
    import ucx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               in_valid,
    input logic               in_ready,
    input logic [INSTR_W-1:0] in_instr,
    input logic               out_valid,
    input logic               out_ready,
    input logic [INSTR_W-1:0] out_instr,
    input logic [DISP_W-1:0]  out_disp,
    input logic [UC_W-1:0]    out_use_count,
    input logic               out_is_mem,
    input logic               out_fused
);
    a_r3_short_disp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_valid && out_is_mem && !out_fused) |->
            (out_disp == sext_short(in_instr[SHORT_W-1:0]) &&
             out_use_count == in_instr[IMM_W-1 -: UC_W] &&
             out_instr[INSTR_W-1:IMM_W] == in_instr[INSTR_W-1:IMM_W]));

    a_r5_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[OPC_LSB +: OPC_W] == PREFIX_OPC) |-> !out_valid);

    a_r9_flush_blocks: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!in_ready && !out_valid));

    a_r6_fuse_needs_live_prefix: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fused) |-> (!$past(flush) && out_is_mem));

    a_r10_ready_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && in_instr[OPC_LSB +: OPC_W] != PREFIX_OPC)
            |-> (in_ready == out_ready));

    a_r2_no_disp_off_mem: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_mem) |-> (out_disp == '0 && !out_fused));
endmodule

bind dispatch_usecount_fuser ucx_checker i_chk (.*);

// File: tb/test_dispatch_usecount_fuser.sv
module test_dispatch_usecount_fuser;
    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_instr;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_instr;
    logic [5:0]  out_opcode;
    logic [4:0]  out_ra;
    logic [4:0]  out_rb;
    logic [63:0] out_disp;
    logic [2:0]  out_use_count;
    logic        out_is_mem;
    logic        out_fused;

    dispatch_usecount_fuser i_dispatch_usecount_fuser (.*);

    always #10 clk = ~clk;

    typedef struct packed {
        logic [31:0] instr;
        logic [63:0] disp;
        logic [2:0]  uc;
        logic        is_mem;
        logic        fused;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    logic        pv = 1'b0;
    logic [15:0] pimm = '0;
    bit    done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // expected slot computed from the requirement text
    function automatic exp_t expect_of(input logic [31:0] w, input logic have_p,
                                       input logic [15:0] p);
        exp_t e;
        e = '0;
        e.instr = w;
        if (w[31:30] == 2'b01) begin
            e.uc = w[11:9];
            e.instr[11:9] = 3'b000;
        end else if (w[31:30] == 2'b10) begin
            e.uc = w[15:13];
            e.is_mem = 1'b1;
            if (have_p) begin
                e.disp = {{48{p[15]}}, p};
                e.fused = 1'b1;
            end else begin
                e.disp = {{51{w[12]}}, w[12:0]};
            end
            e.instr[15:0] = e.disp[15:0];
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] w, input string tag);
        bit hs;
        if (w[31:26] == 6'h3F) begin
            pv = 1'b1;
            pimm = w[15:0];
        end else begin
            exp_q.push_back(expect_of(w, pv, pimm));
            tag_q.push_back(tag);
            pv = 1'b0;
        end
        in_valid = 1'b1;
        in_instr = w;
        forever begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk);
            #1;
            if (hs) break;
        end
        in_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever a slot transfers
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R5", "unexpected slot", {32'h0, out_instr}, 64'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_instr == e.instr, t, "instr", {32'h0, out_instr}, {32'h0, e.instr});
                check(out_disp == e.disp, t, "disp", out_disp, e.disp);
                check(out_use_count == e.uc, t, "use count", {61'h0, out_use_count}, {61'h0, e.uc});
                check(out_is_mem == e.is_mem && out_fused == e.fused, t, "mem/fused",
                      {62'h0, out_is_mem, out_fused}, {62'h0, e.is_mem, e.fused});
                check(out_opcode == e.instr[31:26] && out_ra == e.instr[25:21] &&
                      out_rb == e.instr[20:16], t, "fields",
                      {48'h0, out_opcode, out_ra, out_rb}, {48'h0, e.instr[31:16]});
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_instr = '0; out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1", "idle after reset",
              {62'h0, out_valid, in_ready}, 64'h1);
        @(posedge clk); #1;

        // R2 operate with count 5
        send({6'h11, 5'd3, 5'd4, 4'hA, 3'd5, 4'h6, 5'd7}, "R2");
        send({6'h1F, 5'd31, 5'd0, 4'h0, 3'd7, 4'hF, 5'd1}, "R2");
        // R3 memory, positive and negative short displacement, count 7
        send({6'h28, 5'd1, 5'd2, 3'd2, 13'h0123}, "R3");
        send({6'h2C, 5'd9, 5'd10, 3'd7, 13'h1F00}, "R3");
        // R4 other opcodes
        send({6'h05, 5'd6, 5'd7, 16'hE5A5}, "R4");
        send({6'h3E, 5'd1, 5'd1, 16'hFFFF}, "R4");

        // R5 prefix accepted with output stalled, no slot raised
        out_ready = 1'b0;
        in_valid = 1'b1;
        in_instr = {6'h3F, 10'h0, 16'h8001};
        @(negedge clk);
        check(in_ready && !out_valid, "R5", "prefix absorbed under stall",
              {62'h0, in_ready, out_valid}, 64'h2);
        @(posedge clk); #1;
        in_valid = 1'b0; pv = 1'b1; pimm = 16'h8001;
        out_ready = 1'b1;
        // R6 fused memory word with negative long offset
        send({6'h20, 5'd4, 5'd5, 3'd3, 13'h0004}, "R6");
        // R6 fused positive offset, then the prefix is gone: R3
        send({6'h3F, 10'h3FF, 16'h7ABC}, "R6");
        send({6'h21, 5'd2, 5'd3, 3'd1, 13'h1FFF}, "R6");
        send({6'h21, 5'd2, 5'd3, 3'd1, 13'h1FFF}, "R3");

        // R7 prefix dropped by operate follower
        send({6'h3F, 10'h0, 16'h1234}, "R7");
        send({6'h12, 5'd8, 5'd9, 4'h1, 3'd4, 4'h2, 5'd3}, "R7");
        send({6'h22, 5'd8, 5'd9, 3'd0, 13'h0010}, "R7");

        // R8 second prefix replaces the first
        send({6'h3F, 10'h0, 16'h1111}, "R8");
        send({6'h3F, 10'h0, 16'hC000}, "R8");
        send({6'h23, 5'd0, 5'd1, 3'd6, 13'h0001}, "R8");

        // R9 flush in the same cycle as the follower
        send({6'h3F, 10'h0, 16'h4444}, "R9");
        flush = 1'b1;
        in_valid = 1'b1;
        in_instr = {6'h24, 5'd1, 5'd1, 3'd2, 13'h0FF0};
        @(negedge clk);
        check(!out_valid && !in_ready, "R9", "flush blocks follower",
              {62'h0, out_valid, in_ready}, 64'h0);
        @(posedge clk); #1;
        flush = 1'b0; in_valid = 1'b0; pv = 1'b0;
        send({6'h24, 5'd1, 5'd1, 3'd2, 13'h0FF0}, "R9");

        // R10 stall while a fused slot waits
        send({6'h3F, 10'h0, 16'hFFFE}, "R10");
        out_ready = 1'b0;
        exp_q.push_back(expect_of({6'h25, 5'd3, 5'd3, 3'd5, 13'h0002}, 1'b1, 16'hFFFE));
        tag_q.push_back("R10");
        pv = 1'b0;
        in_valid = 1'b1;
        in_instr = {6'h25, 5'd3, 5'd3, 3'd5, 13'h0002};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid && !in_ready && out_fused, "R10", "stalled slot held",
                  {61'h0, out_valid, in_ready, out_fused}, 64'h5);
            @(posedge clk); #1;
        end
        out_ready = 1'b1;
        @(negedge clk);
        check(in_ready, "R10", "ready follows out_ready", {63'h0, in_ready}, 64'h1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R10", "scoreboard drained",
              64'(exp_q.size()), 64'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule